// File: doc/BRIEF.md
# Coprocessor Register Access Scan Chain

This block is a JTAG data register on the target side. While the core is halted, it lets a debug host read and write a bank of 32-bit system-control registers. A standard TAP controller, built elsewhere, supplies the test clock, the serial input, the capture, shift and update strobes, and a qualifier that is high when this chain is the selected one. The block drives the serial output back to the TAP.

On the core side, the block starts register accesses over a plain request/ready port in the core clock domain. Requests cross between the two clock domains through toggle handshakes with two-flop synchronisers.

The host uses the chain like this:
- It shifts in one 48-bit frame that carries the address, the direction and the write data, with the access strobe set. The update strobe then launches the access.
- It keeps rescanning with the strobe cleared. Each capture returns a completion bit and, after a read, the register value.

Top module: `cp_scan_chain`

## Requirements
- R1: The frame is 48 bits, shifted least significant bit first. Bits 31:0 hold data, bit 32 is the access strobe, bits 46:33 hold the register address and bit 47 is the write flag. tdo_o always shows bit 0 of the shift register, so a frame shifted in without capture comes back unchanged on the next shift.
- R2: The 14-bit address holds four fields: primary opcode in bits 13:11, secondary opcode in bits 10:8, major register number in bits 7:4 and minor register number in bits 3:0. The address is passed unchanged to reg_addr_o.
- R3: When an update carries strobe 1 and write flag 1, the block issues one core write of the 32-bit data field to the addressed register.
- R4: When an update carries strobe 1 and write flag 0, the block issues one core read. Once the access is complete, a capture loads the returned value into bits 31:0.
- R5: A scan whose strobe bit is 0 never issues a core request. It leaves register contents and the held access fields unchanged.
- R6: On capture, bit 32 is 1 when the last accepted access has completed and 0 while it is still pending.
- R7: An update with strobe 1 that arrives while an access is pending is ignored. The pending access completes with its own address and data.
- R8: reg_req_o stays high, with its address, direction and data stable, until reg_ready_i is sampled high. Each accepted access that decodes produces exactly one request.
- R9: An access decodes only when bit crn of CRN_MASK and bit op1 of OP1_MASK are both set. An access that does not decode raises no request and completes on its own. A read of such an address returns 0, and a write to it is discarded.
- R10: After reset, a capture returns the frame with only bit 32 set: completion bit 1 and all other fields 0.
- R11: After an access is accepted, a capture returns its address in bits 46:33 and its write flag in bit 47.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| tck_i | input | 1 | Test clock |
| tdi_i | input | 1 | Serial data in |
| sel_i | input | 1 | Chain selected by the TAP |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| tdo_o | output | 1 | Serial data out |
| reg_req_o | output | 1 | Core access request |
| reg_we_o | output | 1 | Core access is a write |
| reg_addr_o | output | 14 | Packed register address |
| reg_wdata_o | output | 32 | Write data |
| reg_rdata_i | input | 32 | Read data |
| reg_ready_i | input | 1 | Core access complete |

## Verification
The bench builds the block with CRN_MASK = 16'h80E7 and OP1_MASK = 8'h81. With these masks, both a hit and a miss can be reached in each of the two decoded fields. Primary opcode 7 together with major number 15 reaches the top address bits and so exercises the packing. Major number 3, or primary opcode 1, reaches the path that completes on its own. Random addresses drawn from mostly decoding values reuse registers often enough that read-after-write checks hit stored data. A stall input on the bench's register model holds an access pending, which makes the busy completion bit and the ignored update deterministic.

// File: rtl/cp_scan_pkg.sv
package cp_scan_pkg;
  localparam int DATA_W  = 32;
  localparam int OP_W    = 3;
  localparam int CR_W    = 4;
  localparam int ADDR_W  = 2 * OP_W + 2 * CR_W;
  localparam int FRAME_W = DATA_W + ADDR_W + 2;

  // LSB first on the wire: data, access, addr, we
  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic              access;
    logic [DATA_W-1:0] data;
  } frame_t;

  typedef struct packed {
    logic [OP_W-1:0] op1;
    logic [OP_W-1:0] op2;
    logic [CR_W-1:0] crn;
    logic [CR_W-1:0] crm;
  } cp_addr_t;
endpackage

// File: rtl/cp_scan_sync.sv
module cp_scan_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/cp_scan_shreg.sv
module cp_scan_shreg
  import cp_scan_pkg::*;
(
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tdi_i,
  input  logic              sel_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  output logic              tdo_o,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              req_tgl_o,
  output logic              done_o,
  output logic              hold_we_o,
  output logic [ADDR_W-1:0] hold_addr_o,
  output logic [DATA_W-1:0] hold_data_o
);
  logic [FRAME_W-1:0] sr_q;
  frame_t             upd_f, cap_f;
  logic               req_tgl_q, hold_we_q;
  logic [ADDR_W-1:0]  hold_addr_q;
  logic [DATA_W-1:0]  hold_data_q;
  logic               done;

  assign done  = (req_tgl_q == ack_i);
  assign upd_f = frame_t'(sr_q);

  always_comb begin
    cap_f.we     = hold_we_q;
    cap_f.addr   = hold_addr_q;
    cap_f.access = done;
    cap_f.data   = rdata_i;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q        <= '0;
      req_tgl_q   <= 1'b0;
      hold_we_q   <= 1'b0;
      hold_addr_q <= '0;
      hold_data_q <= '0;
    end else if (sel_i) begin
      if (capture_i) begin
        sr_q <= cap_f;
      end else if (shift_i) begin
        sr_q <= {tdi_i, sr_q[FRAME_W-1:1]};
      end else if (update_i && upd_f.access && done) begin
        hold_we_q   <= upd_f.we;
        hold_addr_q <= upd_f.addr;
        hold_data_q <= upd_f.data;
        req_tgl_q   <= ~req_tgl_q;
      end
    end
  end

  assign tdo_o       = sr_q[0];
  assign req_tgl_o   = req_tgl_q;
  assign done_o      = done;
  assign hold_we_o   = hold_we_q;
  assign hold_addr_o = hold_addr_q;
  assign hold_data_o = hold_data_q;
endmodule

// File: rtl/cp_scan_decode.sv
module cp_scan_decode
  import cp_scan_pkg::*;
#(
  parameter logic [2**CR_W-1:0] CRN_MASK = 16'h80E7,
  parameter logic [2**OP_W-1:0] OP1_MASK = 8'h81
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  cp_addr_t a;
  logic     unused_fields;

  assign a             = cp_addr_t'(addr_i);
  assign hit_o         = CRN_MASK[a.crn] & OP1_MASK[a.op1];
  assign unused_fields = ^{a.op2, a.crm};
endmodule

// File: rtl/cp_scan_core.sv
module cp_scan_core
  import cp_scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_tgl_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hit_i,
  output logic              reg_req_o,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic              reg_ready_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_tgl_o
);
  typedef enum logic {ST_IDLE, ST_BUSY} st_e;

  st_e               st_q;
  logic              seen_q, ack_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      seen_q  <= 1'b0;
      ack_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_tgl_i != seen_q) begin
            seen_q  <= req_tgl_i;
            we_q    <= we_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            if (hit_i) begin
              st_q <= ST_BUSY;
            end else begin
              // undecoded: finish at once, reads give zero
              if (!we_i) rdata_q <= '0;
              ack_q <= ~ack_q;
            end
          end
        end
        ST_BUSY: begin
          if (reg_ready_i) begin
            if (!we_q) rdata_q <= reg_rdata_i;
            ack_q <= ~ack_q;
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign reg_req_o   = (st_q == ST_BUSY);
  assign reg_we_o    = we_q;
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;
  assign rdata_o     = rdata_q;
  assign ack_tgl_o   = ack_q;
endmodule

// File: rtl/cp_scan_chain.sv
module cp_scan_chain
  import cp_scan_pkg::*;
#(
  parameter logic [2**CR_W-1:0] CRN_MASK = 16'h80E7,
  parameter logic [2**OP_W-1:0] OP1_MASK = 8'h81
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tck_i,
  input  logic              tdi_i,
  input  logic              sel_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  output logic              tdo_o,
  output logic              reg_req_o,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic              reg_ready_i
);
  logic              req_tgl_w, req_tgl_sync, ack_tgl_w, ack_tgl_sync;
  logic              done_w, hold_we_w, hit_w;
  logic [ADDR_W-1:0] hold_addr_w;
  logic [DATA_W-1:0] hold_data_w, rdata_w;

  cp_scan_shreg u_shreg (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .tdi_i      (tdi_i),
    .sel_i      (sel_i),
    .capture_i  (capture_i),
    .shift_i    (shift_i),
    .update_i   (update_i),
    .tdo_o      (tdo_o),
    .ack_i      (ack_tgl_sync),
    .rdata_i    (rdata_w),
    .req_tgl_o  (req_tgl_w),
    .done_o     (done_w),
    .hold_we_o  (hold_we_w),
    .hold_addr_o(hold_addr_w),
    .hold_data_o(hold_data_w)
  );

  cp_scan_sync #(.W(1)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_tgl_w),
    .q_o   (req_tgl_sync)
  );

  cp_scan_sync #(.W(1)) u_ack_sync (
    .clk_i (tck_i),
    .rst_ni(rst_ni),
    .d_i   (ack_tgl_w),
    .q_o   (ack_tgl_sync)
  );

  cp_scan_decode #(.CRN_MASK(CRN_MASK), .OP1_MASK(OP1_MASK)) u_dec (
    .addr_i(hold_addr_w),
    .hit_o (hit_w)
  );

  cp_scan_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_tgl_i  (req_tgl_sync),
    .we_i       (hold_we_w),
    .addr_i     (hold_addr_w),
    .wdata_i    (hold_data_w),
    .hit_i      (hit_w),
    .reg_req_o  (reg_req_o),
    .reg_we_o   (reg_we_o),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_rdata_i(reg_rdata_i),
    .reg_ready_i(reg_ready_i),
    .rdata_o    (rdata_w),
    .ack_tgl_o  (ack_tgl_w)
  );
endmodule

// File: rtl/cp_scan_chain_chk.sv
module cp_scan_chain_chk
  import cp_scan_pkg::*;
(
  input logic              clk_i,
  input logic              tck_i,
  input logic              rst_ni,
  input logic              reg_req_o,
  input logic              reg_ready_i,
  input logic              reg_we_o,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic [DATA_W-1:0] reg_wdata_o,
  input logic              req_tgl,
  input logic              done,
  input logic              hold_we,
  input logic [ADDR_W-1:0] hold_addr
);
  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ready_i |=> reg_req_o && $stable(reg_addr_o) && $stable(reg_we_o) && $stable(reg_wdata_o));

  assert_req_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reg_req_o) |-> $past(reg_ready_i));

  assert_accept_idle_R7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !$stable(req_tgl) |-> $past(done));

  assert_noop_quiet_R5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!$stable(hold_addr) || !$stable(hold_we)) |-> !$stable(req_tgl));

  assert_pending_busy_R6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !$stable(req_tgl) |-> !done);
endmodule

bind cp_scan_chain cp_scan_chain_chk u_chk (
  .clk_i      (clk_i),
  .tck_i      (tck_i),
  .rst_ni     (rst_ni),
  .reg_req_o  (reg_req_o),
  .reg_ready_i(reg_ready_i),
  .reg_we_o   (reg_we_o),
  .reg_addr_o (reg_addr_o),
  .reg_wdata_o(reg_wdata_o),
  .req_tgl    (req_tgl_w),
  .done       (done_w),
  .hold_we    (hold_we_w),
  .hold_addr  (hold_addr_w)
);

// File: tb/cp_scan_chain_test.sv
`timescale 1ns/1ps
module cp_scan_chain_test;
  localparam logic [15:0] CRN_M = 16'h80E7;
  localparam logic [7:0]  OP1_M = 8'h81;

  logic clk = 0, tck = 0, rst_n = 0;
  logic tdi = 0, sel = 1, capture = 0, shift = 0, update = 0;
  logic tdo, reg_req, reg_we, ready_q = 0, stall = 0;
  logic [13:0] reg_addr, last_addr = '0;
  logic [31:0] reg_wdata, rdata_q = '0;
  int n_tests = 0, n_fail = 0, port_done = 0, wait_cnt = 0;
  logic [31:0] mem [logic [13:0]];
  logic [31:0] model [logic [13:0]];

  always #5 clk = ~clk;
  always #20 tck = ~tck;

  cp_scan_chain #(.CRN_MASK(CRN_M), .OP1_MASK(OP1_M)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tck_i(tck), .tdi_i(tdi), .sel_i(sel),
    .capture_i(capture), .shift_i(shift), .update_i(update), .tdo_o(tdo),
    .reg_req_o(reg_req), .reg_we_o(reg_we), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(rdata_q), .reg_ready_i(ready_q)
  );

  // register file model with random latency
  always @(posedge clk) begin
    if (reg_req && !ready_q && !stall) begin
      if (wait_cnt == 0) begin
        ready_q <= 1'b1;
        last_addr <= reg_addr;
        if (reg_we) mem[reg_addr] = reg_wdata;
        rdata_q <= mem.exists(reg_addr) ? mem[reg_addr] : 32'h0;
        port_done++;
      end else wait_cnt <= wait_cnt - 1;
    end else begin
      ready_q <= 1'b0;
      if (!reg_req) wait_cnt <= int'($urandom % 4);
    end
  end

  function automatic logic [13:0] pack(input int o1, input int o2, input int n, input int m);
    return {o1[2:0], o2[2:0], n[3:0], m[3:0]};
  endfunction

  function automatic bit decodes(input logic [13:0] a);
    return CRN_M[a[7:4]] && OP1_M[a[13:11]];
  endfunction

  function automatic logic [31:0] expect_rd(input logic [13:0] a);
    if (!decodes(a) || !model.exists(a)) return 32'h0;
    return model[a];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic scan(input bit cap, input bit upd, input logic [47:0] din, output logic [47:0] dout);
    @(negedge tck);
    capture = cap;
    if (cap) @(negedge tck);
    capture = 0;
    for (int i = 0; i < 48; i++) begin
      shift = 1;
      tdi = din[i];
      dout[i] = tdo;
      @(negedge tck);
    end
    shift = 0;
    update = upd;
    if (upd) @(negedge tck);
    update = 0;
  endtask

  task automatic poll(output logic [47:0] f, output bit ok);
    ok = 0;
    for (int p = 0; p < 40; p++) begin
      scan(1, 1, 48'h0, f);
      if (f[32]) begin ok = 1; break; end
    end
  endtask

  task automatic access(input bit we, input logic [13:0] a, input logic [31:0] d,
                        output logic [47:0] f, output bit ok);
    logic [47:0] dummy;
    scan(1, 1, {we, a, 1'b1, d}, dummy);
    poll(f, ok);
    if (ok && we && decodes(a)) model[a] = d;
  endtask

  initial begin
    logic [47:0] f, pat;
    bit ok;
    int pd;
    logic [13:0] a_b, a_c, a_hi, a_u;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(posedge tck);
    rst_n = 1;
    repeat (2) @(posedge tck);

    // R10 reset frame
    scan(1, 0, 48'h0, f);
    check("R10 reset capture", f, 48'h0001_0000_0000);

    // R1 shift order without capture
    pat = 48'hA5C3_9F01_7E6B;
    scan(0, 0, pat, f);
    scan(0, 0, 48'h0, f);
    check("R1 shift-through", f, pat);

    // R3 write, R11 echo
    pd = port_done;
    access(1, pack(0, 0, 1, 0), 32'h1234_5678, f, ok);
    check("R3 write completes", ok, 1);
    check("R3 one core request", port_done - pd, 1);
    check("R3 register written", mem[pack(0, 0, 1, 0)], 32'h1234_5678);
    check("R11 echo addr/we", {f[47], f[46:33]}, {1'b1, pack(0, 0, 1, 0)});

    // R4 read
    access(0, pack(0, 0, 1, 0), 32'h0, f, ok);
    check("R4 read data", f[31:0], 32'h1234_5678);

    // R2 packing at top fields
    a_hi = pack(7, 5, 15, 9);
    access(1, a_hi, 32'hCAFE_F00D, f, ok);
    check("R2 address on port", last_addr, 14'h3DF9);
    access(0, a_hi, 32'h0, f, ok);
    check("R2 readback", f[31:0], 32'hCAFE_F00D);

    // R5 no-op leaves everything alone
    pd = port_done;
    scan(1, 1, {1'b1, pack(0, 0, 1, 0), 1'b0, 32'hDEAD_BEEF}, f);
    repeat (20) @(posedge tck);
    check("R5 no request", port_done - pd, 0);
    scan(1, 0, 48'h0, f);
    check("R5 held fields", {f[47], f[46:33]}, {1'b0, a_hi});
    access(0, pack(0, 0, 1, 0), 32'h0, f, ok);
    check("R5 register unchanged", f[31:0], 32'h1234_5678);

    // R6 / R7 pending behaviour
    a_b = pack(0, 0, 2, 0);
    a_c = pack(0, 0, 5, 0);
    stall = 1;
    pd = port_done;
    scan(1, 1, {1'b1, a_b, 1'b1, 32'h0BAD_CAFE}, f);
    repeat (10) @(posedge tck);
    scan(1, 0, 48'h0, f);
    check("R6 pending shows 0", f[32], 0);
    scan(1, 1, {1'b1, a_c, 1'b1, 32'h7777_7777}, f);
    repeat (10) @(posedge tck);
    scan(1, 0, 48'h0, f);
    check("R7 still pending", f[32], 0);
    check("R7 held addr kept", f[46:33], a_b);
    stall = 0;
    poll(f, ok);
    model[a_b] = 32'h0BAD_CAFE;
    check("R6 completion shows 1", ok, 1);
    check("R7 pending access finished", {f[47], f[46:33]}, {1'b1, a_b});
    check("R7 single request", port_done - pd, 1);
    access(0, a_c, 32'h0, f, ok);
    check("R7 ignored write absent", f[31:0], 32'h0);
    access(0, a_b, 32'h0, f, ok);
    check("R7 first write landed", f[31:0], 32'h0BAD_CAFE);

    // R9 undecoded
    a_u = pack(0, 0, 3, 1);
    pd = port_done;
    access(1, a_u, 32'hFFFF_FFFF, f, ok);
    check("R9 write completes", ok, 1);
    access(0, a_u, 32'h0, f, ok);
    check("R9 read zero", f[31:0], 32'h0);
    access(0, pack(1, 0, 1, 0), 32'h0, f, ok);
    check("R9 op1 miss read zero", f[31:0], 32'h0);
    check("R9 no core request", port_done - pd, 0);

    // random mix: R4, R8, R9
    for (int k = 0; k < 40; k++) begin
      int o1, sel_o;
      logic [13:0] a;
      logic [31:0] d, exp;
      bit we;
      sel_o = int'($urandom % 4);
      o1 = (sel_o == 0) ? 7 : (sel_o == 1) ? int'($urandom % 8) : 0;
      a = pack(o1, int'($urandom % 2), int'($urandom % 16), int'($urandom % 4));
      we = 1'($urandom % 2);
      d = $urandom;
      exp = expect_rd(a);
      pd = port_done;
      access(we, a, d, f, ok);
      check("R8 completes", ok, 1);
      check("R8 request count", port_done - pd, decodes(a) ? 1 : 0);
      if (!we) check("R4 random read", f[31:0], exp);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule